// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block gathers the interrupt events from the DMA side of a bus-mastering script engine into one status byte that the CPU reads and thereby clears. Five events arrive as single-cycle pulses: a data parity error, a bus fault, a software abort, the completion of a single-stepped instruction, and an interrupt instruction that evaluated true. Each pulse sets its own sticky bit. Some of these bits only set when a mode or enable condition allows it.

A separate FIFO-empty level appears live in the byte. It is never latched and never requests an interrupt. A per-bit enable vector chooses which latched events drive the interrupt request. A pending flag shows that any event is latched, whether or not it is enabled.

Reading the byte returns its current value and clears every latched event in the same clock. An event that arrives in the clock of that read survives the clear. Status reads must be at least 12 clocks apart so that stacked interrupts can settle. A read that comes sooner raises a spacing-violation output for that clock, and the read still takes effect.

Top module: `dma_irq_status`

## Requirements
- R1: Bit 7 sets one clock after a pulse on `ev_parity` while `par_chk_en` is 1, and never sets from that pulse while `par_chk_en` is 0.
- R2: Bit 6 sets one clock after a pulse on `ev_bus_fault` only while `bus_master` is 1.
- R3: Bit 5 sets one clock after a pulse on `ev_abort`.
- R4: Bit 4 sets one clock after a pulse on `ev_step_done` only while `step_mode` is 1.
- R5: Bit 3 sets one clock after a pulse on `ev_int_instr`.
- R6: Bit 0 of `rd_data` always equals `fifo_empty` in the same cycle, and bits 2:1 read 0. Neither affects `pending` or `irq`.
- R7: In a cycle with `rd_stb` high, `rd_data` shows the byte before the clear. One clock later, bits 7:3 and `pending` are 0 unless a new event arrived.
- R8: `irq_en[k]` enables status bit k+3 onto `irq`. A disabled event still latches and still raises `pending`. `irq` is 1 exactly when some latched bit has its enable set.
- R9: An event whose pulse coincides with a clearing read is set after that read.
- R10: `spacing_viol` is 1 in a cycle with `rd_stb` high when an earlier read since reset happened fewer than 12 clocks before. Otherwise it is 0.
- R11: After reset, bits 7:3, `pending`, `irq` and `spacing_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_parity | input | 1 | Data parity error pulse |
| ev_bus_fault | input | 1 | Bad-address or target-abort cycle end pulse |
| ev_abort | input | 1 | Software abort command pulse |
| ev_step_done | input | 1 | Instruction completed pulse |
| ev_int_instr | input | 1 | Interrupt instruction true pulse |
| fifo_empty | input | 1 | Live FIFO-empty level |
| irq_en | input | 5 | Per-event enables for bits 7:3 (bit k enables status bit k+3) |
| par_chk_en | input | 1 | Parity-error check enable |
| bus_master | input | 1 | Block currently owns the bus |
| step_mode | input | 1 | Single-step mode active |
| rd_stb | input | 1 | Status read strobe, one per read |
| rd_data | output | 8 | Status byte |
| pending | output | 1 | Some event is latched |
| irq | output | 1 | Some enabled event is latched |
| spacing_viol | output | 1 | Read arrived too soon after the previous one |

## Verification
Random cycles mix all five pulses with random gating levels, enable vectors, FIFO levels and read gaps of 1 to 20 clocks. This separates correct gating and masking from bits that set unconditionally, and separates true violations from the boundary at exactly 12 clocks. Directed cases follow. A parity pulse with checking off shows whether the gate is honoured. A disabled event shows that latching and interrupt requesting are independent. An event in the same clock as a read shows whether the clear loses data. Reads 11 and 12 clocks apart pin down the spacing limit.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int READ_GAP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_parity,
  input  logic       ev_bus_fault,
  input  logic       ev_abort,
  input  logic       ev_step_done,
  input  logic       ev_int_instr,
  input  logic       fifo_empty,
  input  logic [4:0] irq_en,
  input  logic       par_chk_en,
  input  logic       bus_master,
  input  logic       step_mode,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       pending,
  output logic       irq,
  output logic       spacing_viol
);
  localparam int CW = $clog2(READ_GAP + 1);

  logic [4:0]    ev_q;
  logic [4:0]    ev_set;
  logic [CW-1:0] gap_cnt;
  logic          seen_rd;

  assign ev_set = {ev_parity & par_chk_en,
                   ev_bus_fault & bus_master,
                   ev_abort,
                   ev_step_done & step_mode,
                   ev_int_instr};

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (rd_stb ? 5'b0 : ev_q) | ev_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= CW'(READ_GAP);
      seen_rd <= 1'b0;
    end else if (rd_stb) begin
      gap_cnt <= CW'(1);
      seen_rd <= 1'b1;
    end else if (gap_cnt != CW'(READ_GAP)) begin
      gap_cnt <= gap_cnt + CW'(1);
    end
  end

  assign rd_data      = {ev_q, 2'b00, fifo_empty};
  assign pending      = |ev_q;
  assign irq          = |(ev_q & irq_en);
  assign spacing_viol = rd_stb & seen_rd & (gap_cnt < CW'(READ_GAP));

  AST_PAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> $past(ev_parity && par_chk_en)); // R1
  AST_BF_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[6]) |-> $past(ev_bus_fault && bus_master)); // R2
  AST_STEP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[4]) |-> $past(ev_step_done && step_mode)); // R4
  AST_INT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int_instr |=> rd_data[3]); // R5
  AST_FIFO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:3] == 5'b0) |-> (!pending && !irq && rd_data[2:1] == 2'b0)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ev_parity && !ev_bus_fault && !ev_abort && !ev_step_done && !ev_int_instr)
      |=> (rd_data[7:3] == 5'b0 && !pending)); // R7
  AST_ABORT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ev_abort) |=> rd_data[5]); // R9
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $past(rd_stb)) |-> spacing_viol); // R10
endmodule

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
  logic clk = 0, rst_n = 0;
  logic ev_parity = 0, ev_bus_fault = 0, ev_abort = 0, ev_step_done = 0, ev_int_instr = 0;
  logic fifo_empty = 0, par_chk_en = 0, bus_master = 0, step_mode = 0, rd_stb = 0;
  logic [4:0] irq_en = 0;
  logic [7:0] rd_data;
  logic pending, irq, spacing_viol;

  int tests = 0, fails = 0;
  logic [4:0] exp_q = 0;
  int cyc = 0, last_rd = 0;
  bit armed = 0;

  dma_irq_status uut (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] set_bits();
    return {ev_parity & par_chk_en, ev_bus_fault & bus_master, ev_abort,
            ev_step_done & step_mode, ev_int_instr};
  endfunction

  function automatic logic [7:0] exp_byte();
    return {exp_q, 2'b00, fifo_empty};
  endfunction

  task automatic step();
    #1;
    chk("R6/R7 rd_data", rd_data, exp_byte());
    chk("R8 pending", pending, |exp_q);
    chk("R8 irq", irq, |(exp_q & irq_en));
    chk("R10 spacing_viol", spacing_viol, rd_stb & armed & ((cyc - last_rd) < 12));
    @(posedge clk);
    exp_q = (rd_stb ? 5'b0 : exp_q) | set_bits();
    if (rd_stb) begin armed = 1; last_rd = cyc; end
    cyc++;
    @(negedge clk);
    {ev_parity, ev_bus_fault, ev_abort, ev_step_done, ev_int_instr, rd_stb} = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset byte", rd_data[7:3], 0);
    chk("R11 reset pending", pending, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset viol", spacing_viol, 0);

    irq_en = 5'h1f; par_chk_en = 0; ev_parity = 1; step();
    chk("R1 parity gated off", rd_data[7], 0);
    par_chk_en = 1; ev_parity = 1; step();
    chk("R1 parity set", rd_data[7], 1);
    bus_master = 0; ev_bus_fault = 1; step();
    chk("R2 fault not master", rd_data[6], 0);
    bus_master = 1; ev_bus_fault = 1; step();
    chk("R2 fault as master", rd_data[6], 1);
    ev_abort = 1; step();
    chk("R3 abort", rd_data[5], 1);
    step_mode = 0; ev_step_done = 1; step();
    chk("R4 step off", rd_data[4], 0);
    step_mode = 1; ev_step_done = 1; step();
    chk("R4 step on", rd_data[4], 1);
    ev_int_instr = 1; step();
    chk("R5 int instr", rd_data[3], 1);
    fifo_empty = 1; #1 chk("R6 fifo live", rd_data[0], 1);
    rd_stb = 1; step();
    chk("R7 cleared", rd_data[7:3], 0);
    chk("R7 pending dropped", pending, 0);
    idle(12);
    irq_en = 5'b01111; par_chk_en = 1; ev_parity = 1; step();
    chk("R8 masked latch", rd_data[7], 1);
    chk("R8 masked pending", pending, 1);
    chk("R8 masked irq", irq, 0);
    rd_stb = 1; ev_abort = 1; step();
    chk("R9 abort kept", rd_data[5], 1);
    chk("R9 parity cleared", rd_data[7], 0);
    idle(10);
    rd_stb = 1; #1 chk("R10 read at 11", spacing_viol, 1);
    step(); idle(11);
    rd_stb = 1; #1 chk("R10 read at 12", spacing_viol, 0);
    step();

    for (int i = 0; i < 3000; i++) begin
      ev_parity    = ($urandom % 6) == 0;
      ev_bus_fault = ($urandom % 6) == 0;
      ev_abort     = ($urandom % 8) == 0;
      ev_step_done = ($urandom % 5) == 0;
      ev_int_instr = ($urandom % 7) == 0;
      par_chk_en   = $urandom % 2;
      bus_master   = $urandom % 2;
      step_mode    = $urandom % 2;
      fifo_empty   = $urandom % 2;
      if (($urandom % 4) == 0) irq_en = 5'($urandom);
      rd_stb       = ($urandom % 9) == 0;
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule